// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block sits on the host side of an external 12-bit successive-approximation converter. The converter has a start-of-conversion pin and a four-wire serial port. A single pulse on `start` runs one whole frame. The block raises the start-of-conversion line and waits out the conversion time, counted in system clock cycles. It then lowers the line and runs twelve serial clock periods. During those periods it collects the result from the converter's data output and sends the 6-bit setup word for the next conversion. When the frame finishes, the result comes back together with a flag that says whether the sample is two's complement (bipolar) or straight binary (unipolar).

The start-of-conversion pulse has two styles, chosen per frame by `hold_high`:

- **Short style:** the line drops after a brief pulse, so the converter stays fully powered.
- **Hold style:** the line stays up for the whole conversion time, so the converter can drop into a low-power state.

In hold style, the low-power state depends on the power-down bit sent in the previous frame. If that bit was set, the converter goes into deep sleep. The block then holds off the next conversion until a long wake-up interval has passed.

Top module: `sar_adc_ctl`

## Requirements
- R1: After reset, `convst`, `sck`, `sdi`, `busy`, `done`, `result` and `result_bipolar` are all 0.
- R2: A `start` seen while idle with no wake-up pending raises `convst` two clock edges later. A `start` while `busy` is 1 has no effect: it changes neither the frame in flight nor the setup word sent, and it starts no further frame.
- R3: In short style (`hold_high`=0), `convst` stays high for exactly T_PULSE clock cycles.
- R4: In hold style (`hold_high`=1), `convst` stays high for exactly T_CONV clock cycles.
- R5: Serial clock behaviour:
  - `sck` idles low and is never high while `convst` is high.
  - Its first rising edge comes no sooner than T_CONV cycles after the `convst` rising edge.
  - Each frame has exactly 12 `sck` pulses, each half-period lasting CLK_DIV cycles.
- R6: `sdo` is sampled on each `sck` rising edge, MSB first, and the 12 bits form `result`.
- R7: The setup word `cfg` is latched at start and sent on `sdi`, most significant bit first, with each bit set up before the rising edge that captures it.
  - Field layout: `cfg[5]` is single-ended/differential select, `cfg[4]` is odd/sign, `cfg[3:2]` is channel select, `cfg[1]` is UNI (1 = unipolar) and `cfg[0]` is SLP (1 = sleep).
  - `sdi` is 0 for pulses 7 to 12.
- R8: `result_bipolar` is 1 when the UNI bit in effect for that conversion was 0. The bit in effect is the one sent in the previous frame, or 0 after reset.
- R9: Wake-up wait:
  - If a frame ran in hold style while the SLP bit in effect was 1, the next `convst` rising edge comes at least T_WAKE cycles after that frame's `convst` falling edge.
  - Otherwise R2's latency applies.
- R10: `done` is a one-cycle pulse, issued after the twelfth bit is captured. In that same cycle `busy` is 0 and `result` and `result_bipolar` are valid.
- R11: `convst` never rises within T_CONV cycles of its previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| cfg | input | 6 | Setup word for the next conversion |
| hold_high | input | 1 | 1 = hold style, 0 = short style |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| result | output | 12 | Last conversion result |
| result_bipolar | output | 1 | 1 when `result` is two's complement |
| convst | output | 1 | Start-of-conversion line to the converter |
| sck | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Setup word to the converter |
| sdo | input | 1 | Result data from the converter |

## Verification
The bench connects a behavioural converter model and runs frames that alternate the two pulse styles and step the power-down bit through nap, sleep and awake cases. A design that forgot the sleep state would restart too soon after a sleeping frame, which the measured low time of `convst` exposes. A design that dropped `convst` at the wrong point would show a pulse width other than T_PULSE or T_CONV.

The polarity flag is checked against the previous frame's UNI bit. A flag taken from the current word shows up on every frame where that bit changes. Start pulses issued mid-frame must not disturb the setup word the model receives, and must not trigger a second conversion.

// File: rtl/sar_adc_ctl.sv
module sar_adc_ctl #(
  parameter int CLK_DIV = 4,
  parameter int T_PULSE = 4,
  parameter int T_CONV  = 163,
  parameter int T_WAKE  = 25000000,
  parameter int RES_W   = 12,
  parameter int CFG_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg,
  input  logic             hold_high,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             result_bipolar,
  output logic             convst,
  output logic             sck,
  output logic             sdi,
  input  logic             sdo
);
  localparam int CW = $clog2(T_CONV + 1);
  localparam int WW = $clog2(T_WAKE + 1);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int BW = $clog2(RES_W + 1);
  localparam int UNI_BIT = 1;
  localparam int SLP_BIT = 0;

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_CONV, S_SHIFT} state_t;
  state_t state;

  logic [CW-1:0]    cnt;
  logic [WW-1:0]    wake_cnt;
  logic [DW-1:0]    div;
  logic [BW-1:0]    nbit;
  logic [CFG_W-1:0] cfg_q, tx;
  logic [RES_W-1:0] rx;
  logic             hold_q, uni_eff, slp_eff;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      cnt            <= '0;
      wake_cnt       <= '0;
      div            <= '0;
      nbit           <= '0;
      cfg_q          <= '0;
      tx             <= '0;
      rx             <= '0;
      hold_q         <= 1'b0;
      uni_eff        <= 1'b0;
      slp_eff        <= 1'b0;
      done           <= 1'b0;
      result         <= '0;
      result_bipolar <= 1'b0;
      convst         <= 1'b0;
      sck            <= 1'b0;
      sdi            <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wake_cnt != '0) wake_cnt <= wake_cnt - WW'(1);
      case (state)
        S_IDLE: if (start) begin
          cfg_q  <= cfg;
          hold_q <= hold_high;
          state  <= S_WAKE;
        end
        S_WAKE: if (wake_cnt == '0) begin
          convst <= 1'b1;
          cnt    <= CW'(1);
          state  <= S_CONV;
        end
        S_CONV: begin
          cnt <= cnt + CW'(1);
          if (!hold_q && cnt == CW'(T_PULSE)) convst <= 1'b0;
          if (cnt == CW'(T_CONV)) begin
            convst <= 1'b0;
            state  <= S_SHIFT;
            div    <= '0;
            nbit   <= '0;
            tx     <= cfg_q;
            sdi    <= cfg_q[CFG_W-1];
            if (hold_q && slp_eff) wake_cnt <= WW'(T_WAKE);
          end
        end
        S_SHIFT: begin
          if (div == DW'(CLK_DIV - 1)) begin
            div <= '0;
            sck <= ~sck;
            if (!sck) begin
              rx   <= {rx[RES_W-2:0], sdo};
              nbit <= nbit + BW'(1);
            end else if (nbit == BW'(RES_W)) begin
              state          <= S_IDLE;
              done           <= 1'b1;
              result         <= rx;
              result_bipolar <= ~uni_eff;
              uni_eff        <= cfg_q[UNI_BIT];
              slp_eff        <= cfg_q[SLP_BIT];
              sdi            <= 1'b0;
            end else begin
              tx  <= {tx[CFG_W-2:0], 1'b0};
              sdi <= tx[CFG_W-2];
            end
          end else begin
            div <= div + DW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_ctl_chk.sv
module sar_adc_ctl_chk #(
  parameter int T_PULSE = 4,
  parameter int T_CONV  = 163
) (
  input logic clk,
  input logic rst_n,
  input logic convst,
  input logic sck,
  input logic busy,
  input logic done
);
  localparam int CW = $clog2(T_CONV + 1);
  logic [CW-1:0] gap;
  logic          convst_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= CW'(T_CONV);
      convst_d <= 1'b0;
    end else begin
      convst_d <= convst;
      if (convst && !convst_d) gap <= CW'(1);
      else if (gap < CW'(T_CONV)) gap <= gap + CW'(1);
    end
  end

  assert_restart_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst) |-> gap >= CW'(T_CONV));
  assert_fall_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst) |-> (gap <= CW'(T_PULSE) || gap >= CW'(T_CONV)));
  assert_read_after_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> gap >= CW'(T_CONV));
  assert_sck_low_in_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !convst);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind sar_adc_ctl sar_adc_ctl_chk #(.T_PULSE(T_PULSE), .T_CONV(T_CONV)) u_chk (
  .clk(clk), .rst_n(rst_n), .convst(convst), .sck(sck), .busy(busy), .done(done)
);

// File: tb/sar_adc_ctl_tb.sv
module sar_adc_ctl_tb;
  localparam int CLK_DIV = 2;
  localparam int T_PULSE = 4;
  localparam int T_CONV  = 163;
  localparam int T_WAKE  = 2000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, hold_i = 1'b0;
  logic [5:0] cfg_i = '0;
  logic busy, done, result_bipolar, convst, sck, sdi, sdo;
  logic [11:0] result;

  sar_adc_ctl #(.CLK_DIV(CLK_DIV), .T_PULSE(T_PULSE), .T_CONV(T_CONV), .T_WAKE(T_WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg_i), .hold_high(hold_i),
    .busy(busy), .done(done), .result(result), .result_bipolar(result_bipolar),
    .convst(convst), .sck(sck), .sdi(sdi), .sdo(sdo));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // converter model
  logic [11:0] next_sample = '0, adc_sr = '0;
  logic [5:0]  cfg_rx = '0;
  int          nsck = 0;
  assign sdo = adc_sr[11];
  always @(posedge convst or negedge sck) begin
    if (convst) adc_sr <= next_sample;
    else adc_sr <= {adc_sr[10:0], 1'b0};
  end

  int t_rise = -100000, t_fall = 0;
  bit exp_hold = 0, wake_exp = 0;
  always @(posedge sck or posedge convst) begin
    if (convst) nsck <= 0;
    else begin
      if (nsck == 0) check(cyc - t_rise >= T_CONV, "R5 first sck after conversion", cyc - t_rise, T_CONV);
      if (nsck < 6) cfg_rx[5 - nsck] <= sdi;
      else check(sdi == 1'b0, "R7 sdi low after word", sdi, 0);
      nsck <= nsck + 1;
    end
  end
  always @(posedge convst) begin
    check(cyc - t_rise >= T_CONV, "R11 restart gap", cyc - t_rise, T_CONV);
    if (wake_exp) check(cyc - t_fall >= T_WAKE, "R9 wake wait", cyc - t_fall, T_WAKE);
    t_rise = cyc;
  end
  always @(negedge convst) begin
    t_fall = cyc;
    if (exp_hold) check(cyc - t_rise == T_CONV, "R4 hold width", cyc - t_rise, T_CONV);
    else check(cyc - t_rise == T_PULSE, "R3 short width", cyc - t_rise, T_PULSE);
  end

  bit uni_prev = 0, slp_prev = 0, wake_next = 0;

  task automatic run_frame(input bit hold, input logic [5:0] cfg, input logic [11:0] sample,
                           input bit poke);
    int lat, w;
    next_sample = sample;
    exp_hold = hold;
    wake_exp = wake_next;
    @(negedge clk);
    start = 1'b1; cfg_i = cfg; hold_i = hold;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!convst && lat < 100000) begin @(negedge clk); lat++; end
    if (!wake_exp) check(lat == 2, "R2 start latency", lat, 2);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; cfg_i = ~cfg; hold_i = ~hold;
      @(negedge clk);
      start = 1'b0;
      repeat (T_CONV) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; cfg_i = cfg; hold_i = hold;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    check(done == 1'b1, "R10 done seen", done, 1);
    check(busy == 1'b0, "R10 busy low at done", busy, 0);
    check(result == sample, "R6 result", result, sample);
    check(result_bipolar == ~uni_prev, "R8 polarity flag", result_bipolar, ~uni_prev);
    check(cfg_rx == cfg, "R7 setup word", cfg_rx, cfg);
    check(nsck == 12, "R5 pulse count", nsck, 12);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    wake_next = hold && slp_prev;
    slp_prev = cfg[0];
    uni_prev = cfg[1];
  endtask

  // {hold, cfg[5:0], sample[11:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 6'b100010, 12'hA5C},
    {1'b1, 6'b100001, 12'h3FF},
    {1'b1, 6'b010110, 12'h800},
    {1'b0, 6'b111011, 12'h001},
    {1'b1, 6'b001100, 12'hFFF},
    {1'b0, 6'b110101, 12'h000},
    {1'b1, 6'b000011, 12'h5A5},
    {1'b0, 6'b101110, 12'h7FE}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({convst, sck, sdi, busy, done} == 5'b0, "R1 reset outputs", {convst, sck, sdi, busy, done}, 0);
    check(result == 12'h0 && result_bipolar == 1'b0, "R1 reset result", result, 0);
    for (int i = 0; i < 8; i++) run_frame(VEC[i][18], VEC[i][17:12], VEC[i][11:0], 1'b0);
    // start pulses while busy must be ignored
    run_frame(1'b0, 6'b100000, 12'h9C3, 1'b1);
    repeat (40) begin
      @(negedge clk);
      check(busy == 1'b0 && convst == 1'b0, "R2 no extra frame", {busy, convst}, 0);
    end
    // sleeping frame followed by a wake-up wait, then polarity after unipolar word
    run_frame(1'b1, 6'b000011, 12'h123, 1'b0);
    run_frame(1'b1, 6'b000010, 12'h456, 1'b0);
    run_frame(1'b0, 6'b000000, 12'h789, 1'b0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R10 watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule